// File: doc/BRIEF.md
# Snoop-Aware Copy-Back Scheduler

This block holds a small set of dirty cache lines that have been evicted and wait to be burst-written to memory. Each slot keeps a line address, the full line of data and an age rank. On every cycle the block names one slot as the next bus candidate and states the priority the copy-back queue should present to the bus arbiter. When the arbiter grants, the named slot leaves the queue.

In the normal case lines leave in the order they arrived, and the queue asks for the bus at the lowest level. A snoop that matches a held line makes the queue urgent, second only to the snoop-push path. It also promotes the newest matching line to the head of the queue. Stale copies of a line are dropped without any bus traffic. Such copies arise when a snoop matches several slots or when the same address is written back twice. The newest data for any address always survives. The line already at the head of the queue is not dropped as a duplicate.

Top module: `cbs_sched`

## Requirements
- R1: After reset no slot is held, `cb_prio` is 0 (idle), `cb_req` is 0, `fill_ready` is 1 and `cancel_mask` is 0.
- R2: A fill is stored when `fill_valid` and `fill_ready` are both 1. `fill_ready` is 0 while all slots are held. A fill offered while `fill_ready` is 0 is dropped and never reaches the bus.
- R3: With no snoop-marked slot, the selected slot is the oldest held line, and `sel_addr`/`sel_data` show its address and line. A grant frees it, and the next-oldest line is selected in the following cycle.
- R4: `cb_prio` is 0 when no slot is held, 1 (lowest) when lines are held and none is snoop-marked, and 2 (second-highest) when any held line is snoop-marked.
- R5: A snoop matching held lines marks the newest matching line. From the next cycle that line is selected ahead of older lines, and `cb_prio` is 2.
- R6: When a snoop matches several held lines, every matching line except the newest is cancelled. The cancellation shows in `cancel_mask` (bit i = slot i) in the snoop cycle and frees those slots at the next edge.
- R7: When two held lines share an address, the older one is cancelled unless it is the currently selected slot. The newest copy is always kept.
- R8: A cancelled slot is freed without a grant, the surviving lines keep their relative age order, and the granted slot is never reported as cancelled.
- R9: `cb_req` is 1 exactly when a line is held and `push_active` is 0. A `bus_grant` while `cb_req` is 0 has no effect.
- R10: Once the snoop-marked line has been granted and no other marked line remains, `cb_prio` returns to 1.
- R11: A snoop whose address matches no held line changes neither the selection, the priority nor the held lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Offer a line to the queue |
| fill_addr | input | ADDR_W | Line address of the offered line |
| fill_data | input | WORDS*WORD_W | Offered line, word 0 in the low bits |
| fill_ready | output | 1 | A free slot exists |
| snoop_valid | input | 1 | Snoop address is valid this cycle |
| snoop_addr | input | ADDR_W | Snooped line address |
| push_active | input | 1 | Snoop-push path is using the bus |
| bus_grant | input | 1 | Arbiter grants the selected line |
| cb_req | output | 1 | Queue requests the bus |
| cb_prio | output | 2 | 0 idle, 1 lowest, 2 second-highest |
| sel_idx | output | IDX_W | Slot chosen for the next write |
| sel_addr | output | ADDR_W | Address of the chosen line |
| sel_data | output | WORDS*WORD_W | Data of the chosen line |
| cancel_mask | output | N_ENTRIES | Slots cancelled at the coming edge |

## Verification
The assertions check several properties on every cycle. The request stays low while the push path is active. An idle queue always accepts fills and never requests, and a full queue refuses them. A granted slot is never also cancelled, and cancels touch only held slots. Age ranks of held slots stay distinct, and a snoop hit without a grant makes the queue urgent one cycle later. The bench scenarios are needed to show the actual orderings. These are fill-order draining, promotion of a later snooped line ahead of an older one, and which copy of a duplicated address survives, including the protected head line. They also show that a missed snoop or a refused fill leaves no trace.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

   typedef enum logic [1:0] {
      PRIO_IDLE   = 2'd0,
      PRIO_LOW    = 2'd1,
      PRIO_URGENT = 2'd2
   } cb_prio_e;

endpackage

// File: rtl/cbs_slot.sv
module cbs_slot #(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 256,
   parameter int RANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LINE_W-1:0] load_data,
   input  logic [RANK_W-1:0] load_rank,
   input  logic              drop,
   input  logic              hot_set,
   input  logic [RANK_W-1:0] rank_nxt,
   output logic              valid_q,
   output logic              hot_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LINE_W-1:0] data_q,
   output logic [RANK_W-1:0] rank_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         hot_q   <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rank_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         hot_q   <= 1'b0;
         addr_q  <= load_addr;
         data_q  <= load_data;
         rank_q  <= load_rank;
      end else if (drop) begin
         valid_q <= 1'b0;
         hot_q   <= 1'b0;
      end else if (valid_q) begin
         rank_q  <= rank_nxt;
         if (hot_set) begin
            hot_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cbs_arb.sv
module cbs_arb #(
   parameter int N_ENTRIES = 3,
   parameter int ADDR_W    = 32,
   parameter int RANK_W    = 2,
   parameter int IDX_W     = 2
) (
   input  logic [N_ENTRIES-1:0]             valid,
   input  logic [N_ENTRIES-1:0]             hot,
   input  logic [N_ENTRIES-1:0][ADDR_W-1:0] addr,
   input  logic [N_ENTRIES-1:0][RANK_W-1:0] rank,
   input  logic                             snoop_valid,
   input  logic [ADDR_W-1:0]                snoop_addr,
   input  logic                             grant_ok,
   output logic                             any_valid,
   output logic                             any_hot,
   output logic                             has_free,
   output logic [IDX_W-1:0]                 sel_idx,
   output logic [IDX_W-1:0]                 free_idx,
   output logic [N_ENTRIES-1:0]             hot_set,
   output logic [N_ENTRIES-1:0]             cancel,
   output logic [N_ENTRIES-1:0]             remove,
   output logic [N_ENTRIES-1:0][RANK_W-1:0] rank_nxt,
   output logic [RANK_W-1:0]                fill_rank
);

   logic [N_ENTRIES-1:0] snp_hit;
   logic [N_ENTRIES-1:0] snp_drop;
   logic [N_ENTRIES-1:0] dup_drop;
   logic [N_ENTRIES-1:0] sel_oh;
   logic [N_ENTRIES-1:0] take;

   assign any_valid = |valid;
   assign any_hot   = |(hot & valid);

   for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_hit
      assign snp_hit[gi] = snoop_valid & valid[gi] & (addr[gi] == snoop_addr);
      assign sel_oh[gi]  = any_valid & (sel_idx == IDX_W'(gi));
   end

   // newer-copy detection for snoop matches and for duplicates
   always_comb begin
      logic newer_hit;
      logic newer_dup;
      for (int i = 0; i < N_ENTRIES; i++) begin
         newer_hit = 1'b0;
         newer_dup = 1'b0;
         for (int j = 0; j < N_ENTRIES; j++) begin
            if (j != i) begin
               if (snp_hit[j] && (rank[j] > rank[i])) newer_hit = 1'b1;
               if (valid[j] && (addr[j] == addr[i]) && (rank[j] > rank[i])) newer_dup = 1'b1;
            end
         end
         hot_set[i]  = snp_hit[i] & ~newer_hit;
         snp_drop[i] = snp_hit[i] & newer_hit;
         dup_drop[i] = valid[i] & newer_dup;
      end
   end

   // head choice: newest marked line, else oldest line
   always_comb begin
      logic              found;
      logic              cand;
      logic [RANK_W-1:0] best;
      found   = 1'b0;
      best    = '0;
      sel_idx = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         cand = any_hot ? (hot[i] & valid[i]) : valid[i];
         if (cand && (!found || (any_hot ? (rank[i] > best) : (rank[i] < best)))) begin
            found   = 1'b1;
            best    = rank[i];
            sel_idx = IDX_W'(i);
         end
      end
   end

   assign take   = sel_oh & {N_ENTRIES{grant_ok}};
   assign cancel = (snp_drop | (dup_drop & ~sel_oh)) & ~take;
   assign remove = take | cancel;

   // compact the age ranks of the survivors
   always_comb begin
      int dec;
      for (int i = 0; i < N_ENTRIES; i++) begin
         dec = 0;
         for (int j = 0; j < N_ENTRIES; j++) begin
            if (remove[j] && (rank[j] < rank[i])) dec = dec + 1;
         end
         rank_nxt[i] = rank[i] - RANK_W'(dec);
      end
   end

   assign fill_rank = RANK_W'($countones(valid & ~remove));

   // lowest free slot
   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            has_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/cbs_sched.sv
module cbs_sched #(
   parameter int N_ENTRIES = 3,
   parameter int WORDS     = 8,
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 32,
   localparam int LINE_W   = WORDS * WORD_W,
   localparam int RANK_W   = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_valid,
   input  logic [ADDR_W-1:0]    fill_addr,
   input  logic [LINE_W-1:0]    fill_data,
   output logic                 fill_ready,
   input  logic                 snoop_valid,
   input  logic [ADDR_W-1:0]    snoop_addr,
   input  logic                 push_active,
   input  logic                 bus_grant,
   output logic                 cb_req,
   output logic [1:0]           cb_prio,
   output logic [IDX_W-1:0]     sel_idx,
   output logic [ADDR_W-1:0]    sel_addr,
   output logic [LINE_W-1:0]    sel_data,
   output logic [N_ENTRIES-1:0] cancel_mask
);
   import cbs_pkg::*;

   if (N_ENTRIES < 2) begin : g_bad_entries
      $error("cbs_sched: N_ENTRIES must be at least 2");
   end
   if (WORDS < 1 || WORD_W < 1 || ADDR_W < 1) begin : g_bad_widths
      $error("cbs_sched: WORDS, WORD_W and ADDR_W must be positive");
   end

   logic [N_ENTRIES-1:0]             valid_q;
   logic [N_ENTRIES-1:0]             hot_q;
   logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q;
   logic [N_ENTRIES-1:0][LINE_W-1:0] data_q;
   logic [N_ENTRIES-1:0][RANK_W-1:0] rank_q;
   logic [N_ENTRIES-1:0][RANK_W-1:0] rank_nxt;
   logic [N_ENTRIES-1:0]             hot_set;
   logic [N_ENTRIES-1:0]             cancel;
   logic [N_ENTRIES-1:0]             remove;
   logic                             any_valid;
   logic                             any_hot;
   logic                             has_free;
   logic [IDX_W-1:0]                 head_idx;
   logic [IDX_W-1:0]                 free_idx;
   logic [RANK_W-1:0]                fill_rank;
   logic                             grant_ok;
   cb_prio_e                         prio;

   assign grant_ok = bus_grant & cb_req;

   cbs_arb #(
      .N_ENTRIES (N_ENTRIES),
      .ADDR_W    (ADDR_W),
      .RANK_W    (RANK_W),
      .IDX_W     (IDX_W)
   ) u_arb (
      .valid       (valid_q),
      .hot         (hot_q),
      .addr        (addr_q),
      .rank        (rank_q),
      .snoop_valid (snoop_valid),
      .snoop_addr  (snoop_addr),
      .grant_ok    (grant_ok),
      .any_valid   (any_valid),
      .any_hot     (any_hot),
      .has_free    (has_free),
      .sel_idx     (head_idx),
      .free_idx    (free_idx),
      .hot_set     (hot_set),
      .cancel      (cancel),
      .remove      (remove),
      .rank_nxt    (rank_nxt),
      .fill_rank   (fill_rank)
   );

   for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_slot
      logic load;
      assign load = fill_valid & has_free & (free_idx == IDX_W'(gi));

      cbs_slot #(
         .ADDR_W (ADDR_W),
         .LINE_W (LINE_W),
         .RANK_W (RANK_W)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .load_addr (fill_addr),
         .load_data (fill_data),
         .load_rank (fill_rank),
         .drop      (remove[gi]),
         .hot_set   (hot_set[gi]),
         .rank_nxt  (rank_nxt[gi]),
         .valid_q   (valid_q[gi]),
         .hot_q     (hot_q[gi]),
         .addr_q    (addr_q[gi]),
         .data_q    (data_q[gi]),
         .rank_q    (rank_q[gi])
      );
   end

   always_comb begin
      if (any_hot)        prio = PRIO_URGENT;
      else if (any_valid) prio = PRIO_LOW;
      else                prio = PRIO_IDLE;
   end

   assign cb_prio     = prio;
   assign cb_req      = any_valid & ~push_active;
   assign fill_ready  = has_free;
   assign sel_idx     = head_idx;
   assign sel_addr    = addr_q[head_idx];
   assign sel_data    = data_q[head_idx];
   assign cancel_mask = cancel;

endmodule

// File: rtl/cbs_sched_chk.sv
module cbs_sched_chk #(
   parameter int N_ENTRIES = 3,
   parameter int ADDR_W    = 32,
   parameter int RANK_W    = 2,
   parameter int IDX_W     = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             push_active,
   input logic                             bus_grant,
   input logic                             cb_req,
   input logic [1:0]                       cb_prio,
   input logic                             fill_ready,
   input logic [N_ENTRIES-1:0]             cancel_mask,
   input logic [IDX_W-1:0]                 sel_idx,
   input logic                             snoop_valid,
   input logic [ADDR_W-1:0]                snoop_addr,
   input logic [N_ENTRIES-1:0]             valid_q,
   input logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q,
   input logic [N_ENTRIES-1:0][RANK_W-1:0] rank_q
);

   logic hit_any;
   always_comb begin
      hit_any = 1'b0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (valid_q[i] && (addr_q[i] == snoop_addr)) hit_any = 1'b1;
      end
   end

   // R9
   push_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_active |-> !cb_req);

   // R4
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cb_prio == 2'd0) |-> (fill_ready && !cb_req));

   // R2
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(valid_q) == N_ENTRIES) |-> !fill_ready);

   // R8
   cancel_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant && cb_req) |-> !cancel_mask[sel_idx]);

   // R6
   cancel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_mask & ~valid_q) == '0);

   // R5
   snoop_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && hit_any && !(bus_grant && cb_req)) |=> (cb_prio == 2'd2));

   for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_pi
      for (genvar gj = gi + 1; gj < N_ENTRIES; gj++) begin : g_pj
         // R8
         rank_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[gi] && valid_q[gj]) |-> (rank_q[gi] != rank_q[gj]));
      end
   end

endmodule

bind cbs_sched cbs_sched_chk #(
   .N_ENTRIES (N_ENTRIES),
   .ADDR_W    (ADDR_W),
   .RANK_W    (RANK_W),
   .IDX_W     (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_active (push_active),
   .bus_grant   (bus_grant),
   .cb_req      (cb_req),
   .cb_prio     (cb_prio),
   .fill_ready  (fill_ready),
   .cancel_mask (cancel_mask),
   .sel_idx     (sel_idx),
   .snoop_valid (snoop_valid),
   .snoop_addr  (snoop_addr),
   .valid_q     (valid_q),
   .addr_q      (addr_q),
   .rank_q      (rank_q)
);

// File: tb/cbs_sched_test.sv
module cbs_sched_test;

   localparam int N  = 3;
   localparam int WW = 32;
   localparam int NW = 8;
   localparam int AW = 32;
   localparam int LW = NW * WW;

   localparam logic [31:0] A = 32'h0000_1000;
   localparam logic [31:0] B = 32'h0000_2000;
   localparam logic [31:0] C = 32'h0000_3000;
   localparam logic [31:0] D = 32'h0000_4000;

   typedef struct packed {
      logic        fv;
      logic [31:0] fa;
      logic        sv;
      logic [31:0] sa;
      logic        gnt;
      logic        psh;
      logic [1:0]  ep;
      logic [31:0] es;
      logic [2:0]  ec;
      logic        er;
   } vec_t;

   // fields: fill, fill addr, snoop, snoop addr, grant, push | prio, head addr, cancel, ready
   localparam int NV = 43;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1}, // R1 empty
      '{1'b1, A,     1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1}, // R2 fill A
      '{1'b1, B,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1}, // R3
      '{1'b1, C,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b0}, // R2 full
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, A,     3'b000, 1'b0}, // R3 grant A
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, B,     3'b000, 1'b1}, // R3 grant B
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 2'd1, C,     3'b000, 1'b1}, // R9 grant while push
      '{1'b1, A,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1}, // C still head
      '{1'b0, 32'h0, 1'b1, A,     1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1}, // R5 snoop A
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd2, A,     3'b000, 1'b1}, // R5 A promoted
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, 2'd2, A,     3'b000, 1'b1}, // R9
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd2, A,     3'b000, 1'b1}, // grant A
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1}, // R10
      '{1'b0, 32'h0, 1'b1, B,     1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1}, // R11 miss
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1}, // R11 no trace
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, C,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1}, // R4 idle
      '{1'b1, A,     1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1},
      '{1'b1, B,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1},
      '{1'b1, A,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1}, // duplicate A
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b0}, // R7 head protected
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, A,     3'b000, 1'b0},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, B,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, B,     3'b000, 1'b1},
      '{1'b1, C,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1},
      '{1'b1, C,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1}, // duplicate C
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b001, 1'b0}, // R7 old C cancelled
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, A,     3'b000, 1'b1}, // R8 slot freed
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1},
      '{1'b1, C,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, C,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b1, C,     1'b0, 1'b0, 2'd1, C,     3'b010, 1'b1}, // R6 multi-hit
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd2, C,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd2, C,     3'b000, 1'b1},
      '{1'b1, A,     1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1},
      '{1'b1, B,     1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b1, B,     1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1}, // R5 snoop newer
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd2, B,     3'b000, 1'b1}, // R5 reorder
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd2, B,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd1, A,     3'b000, 1'b1}, // R10
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd1, A,     3'b000, 1'b1},
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1}, // R9 grant no req
      '{1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0, 3'b000, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              fill_valid;
   logic [AW-1:0]     fill_addr;
   logic [LW-1:0]     fill_data;
   logic              fill_ready;
   logic              snoop_valid;
   logic [AW-1:0]     snoop_addr;
   logic              push_active;
   logic              bus_grant;
   logic              cb_req;
   logic [1:0]        cb_prio;
   logic [1:0]        sel_idx;
   logic [AW-1:0]     sel_addr;
   logic [LW-1:0]     sel_data;
   logic [N-1:0]      cancel_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   cbs_sched #(.N_ENTRIES(N), .WORDS(NW), .WORD_W(WW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_data(fill_data), .fill_ready(fill_ready), .snoop_valid(snoop_valid),
      .snoop_addr(snoop_addr), .push_active(push_active), .bus_grant(bus_grant),
      .cb_req(cb_req), .cb_prio(cb_prio), .sel_idx(sel_idx), .sel_addr(sel_addr),
      .sel_data(sel_data), .cancel_mask(cancel_mask)
   );

   function automatic logic [LW-1:0] line_of(input logic [31:0] a);
      logic [LW-1:0] r;
      for (int w = 0; w < NW; w++) r[w*WW +: WW] = a ^ (32'h0101_0101 * 32'(w + 1));
      return r;
   endfunction

   task automatic check(input string tag, input logic [1:0] ep, input logic [31:0] es,
                        input logic [2:0] ec, input logic er, input logic preq);
      logic ok;
      ok = (cb_prio == ep) && (fill_ready == er) && (cb_req == preq) && (cancel_mask == ec);
      if (ep != 2'd0) ok = ok && (sel_addr == es) && (sel_data == line_of(es));
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: prio=%0d addr=%h ready=%b req=%b cancel=%b expected prio=%0d addr=%h ready=%b req=%b cancel=%b",
                  tag, cb_prio, sel_addr, fill_ready, cb_req, cancel_mask, ep, es, er, preq, ec);
      end
   endtask

   task automatic drive(input logic fv, input logic [31:0] fa, input logic sv,
                        input logic [31:0] sa, input logic g, input logic p);
      @(negedge clk);
      fill_valid  = fv;
      fill_addr   = fa;
      fill_data   = line_of(fa);
      snoop_valid = sv;
      snoop_addr  = sa;
      bus_grant   = g;
      push_active = p;
      #2;
   endtask

   function automatic string tag_of(input vec_t v);
      if (v.ec != 3'b000) return "R6 R7 R8";
      if (v.sv)           return "R5 R11";
      if (v.psh)          return "R9";
      if (v.ep == 2'd2)   return "R5 R10";
      if (v.ep == 2'd0)   return "R1 R4";
      return "R2 R3 R4";
   endfunction

   initial begin
      rst_n = 1'b0;
      fill_valid = 1'b0; fill_addr = '0; fill_data = '0;
      snoop_valid = 1'b0; snoop_addr = '0; push_active = 1'b0; bus_grant = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      check("R1 reset", 2'd0, 32'h0, 3'b000, 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         drive(TBL[k].fv, TBL[k].fa, TBL[k].sv, TBL[k].sa, TBL[k].gnt, TBL[k].psh);
         check(tag_of(TBL[k]), TBL[k].ep, TBL[k].es, TBL[k].ec, TBL[k].er,
               (TBL[k].ep != 2'd0) && !TBL[k].psh);
      end

      // R1: reset from a loaded state
      drive(1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b0;
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
      check("R1 reset clears", 2'd0, 32'h0, 3'b000, 1'b1, 1'b0);
      rst_n = 1'b1;

      // R2: fill offered to a full queue is dropped
      drive(1'b1, A, 1'b0, 32'h0, 1'b0, 1'b0);
      drive(1'b1, B, 1'b0, 32'h0, 1'b0, 1'b0);
      drive(1'b1, C, 1'b0, 32'h0, 1'b0, 1'b0);
      drive(1'b1, D, 1'b0, 32'h0, 1'b0, 1'b0);
      check("R2 full refuses", 2'd1, A, 3'b000, 1'b0, 1'b1);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
      check("R3 head A", 2'd1, A, 3'b000, 1'b0, 1'b1);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
      check("R3 head B", 2'd1, B, 3'b000, 1'b1, 1'b1);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
      check("R3 head C", 2'd1, C, 3'b000, 1'b1, 1'b1);
      drive(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0);
      check("R2 refused fill absent", 2'd0, 32'h0, 3'b000, 1'b1, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule